// File: doc/BRIEF.md
# Sector Read Register Target

A small disk-style target that a host reaches through a byte-wide register bus with a 6-bit offset. The host builds a 29-bit sector address by writing four address bytes, loads a sector count, and may issue a command byte. It then pulls sector contents out of an on-chip byte memory, either two bytes at a time through a 16-bit data port or one byte at a time through a byte data port. Both ports drain a single remaining-byte counter. When that counter runs out, the target forgets the sector address and the count, so the next transfer starts from a clean address.

The sector memory holds `MEM_SECTORS` sectors of 512 bytes each. A separate write port lets the surrounding logic or a testbench preload it. Sector numbers select memory modulo `MEM_SECTORS`. A status register always reports data ready. An error register records whether the last command byte was recognised.

Top module: `ata_pio_target`

## Requirements
- R1: Register reads return `rdata_o` on the clock edge that samples `rd_en_i`, and the value holds until the next read. Offsets are 0x20 (word data), 0x21 (byte data), 0x23 (error on read, feature on write), 0x25 (sector count), 0x27 (address bits 7:0), 0x29 (bits 15:8), 0x2B (bits 23:16), 0x2D (low 5 bits to bits 28:24) and 0x2F (status on read, command on write).
- R2: Each write to an address offset ORs its byte into the sector address at that offset's bit position and never clears any bit.
- R3: A write of N to offset 0x25 sets the remaining count to N×512 bytes and restarts the in-transfer byte position at 0.
- R4: A byte-port read with a nonzero count returns, on bits 7:0 with bits 15:8 zero, the memory byte at (sector mod MEM_SECTORS)×512 + bytes already read. It decrements the count by 1.
- R5: A word-port read with at least 2 bytes left returns the byte at the current position on bits 7:0 and the next byte on bits 15:8, and decrements the count by 2. With exactly 1 byte left, it returns that byte on bits 7:0 with bits 15:8 zero, and the count goes to 0.
- R6: A data read that brings the count to zero also clears the sector address to zero.
- R7: A data-port read with a zero count returns 0 and changes no state.
- R8: A status read (0x2F) always returns 0x08.
- R9: The error register reads 0 after reset. A command byte other than 0x20, 0x30, 0xEC or 0xEF sets it to 0x04. Any of those four codes clears it to 0.
- R10: Reads of any offset other than 0x20, 0x21, 0x23 and 0x2F return 0. Writes to 0x21, 0x23 and unmapped offsets have no effect on the transfer or the error register.
- R11: A backdoor write lands in memory at the clock edge. A data read of the same byte in that same cycle returns the previous content.
- R12: After reset the sector address and count are zero, so a data read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Register offset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 16 | Registered read data |
| bd_we_i | input | 1 | Backdoor memory write enable |
| bd_addr_i | input | MEM_AW | Backdoor byte address |
| bd_data_i | input | 8 | Backdoor write byte |

## Verification
The memory's backdoor write port and a data-port read can touch the same byte in the same cycle. The bench provokes this during a running transfer. In one case it overwrites the very byte being read, and the returned value must be the old content. In the other case it overwrites the byte one position ahead, and the following read must show the new content. A second collision exercised is a word read that meets a single remaining byte: the transfer must both end the count and clear the address on that one read.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  localparam int SEC_W     = 29;
  localparam int SEC_SHIFT = 9;              // 512-byte sectors
  localparam int CNT_W     = 8 + SEC_SHIFT;

  localparam logic [5:0] OFF_WORD  = 6'h20;
  localparam logic [5:0] OFF_BYTE  = 6'h21;
  localparam logic [5:0] OFF_ERR   = 6'h23;
  localparam logic [5:0] OFF_COUNT = 6'h25;
  localparam logic [5:0] OFF_A0    = 6'h27;
  localparam logic [5:0] OFF_A1    = 6'h29;
  localparam logic [5:0] OFF_A2    = 6'h2B;
  localparam logic [5:0] OFF_A3    = 6'h2D;
  localparam logic [5:0] OFF_CMD   = 6'h2F;

  localparam logic [7:0] CMD_RD    = 8'h20;
  localparam logic [7:0] CMD_WR    = 8'h30;
  localparam logic [7:0] CMD_ID    = 8'hEC;
  localparam logic [7:0] CMD_FEAT  = 8'hEF;

  localparam logic [7:0] ST_READY  = 8'h08;
  localparam logic [7:0] ERR_ABORT = 8'h04;

  typedef enum logic [3:0] {
    ACC_NONE, ACC_WORD, ACC_BYTE, ACC_ERR, ACC_COUNT,
    ACC_A0, ACC_A1, ACC_A2, ACC_A3, ACC_CMD
  } acc_e;
endpackage

// File: rtl/ata_pio_regdec.sv
module ata_pio_regdec
  import ata_pio_pkg::*;
(
  input  logic [5:0] addr_i,
  output acc_e       acc_o
);
  always_comb begin
    case (addr_i)
      OFF_WORD:  acc_o = ACC_WORD;
      OFF_BYTE:  acc_o = ACC_BYTE;
      OFF_ERR:   acc_o = ACC_ERR;
      OFF_COUNT: acc_o = ACC_COUNT;
      OFF_A0:    acc_o = ACC_A0;
      OFF_A1:    acc_o = ACC_A1;
      OFF_A2:    acc_o = ACC_A2;
      OFF_A3:    acc_o = ACC_A3;
      OFF_CMD:   acc_o = ACC_CMD;
      default:   acc_o = ACC_NONE;
    endcase
  end
endmodule

// File: rtl/ata_pio_xfer.sv
module ata_pio_xfer
  import ata_pio_pkg::*;
#(
  parameter int MEM_AW = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  acc_e              acc_i,
  input  logic [7:0]        wdata_i,
  output logic [SEC_W-1:0]  sector_o,
  output logic [CNT_W-1:0]  remaining_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic              two_left_o
);
  localparam int LIN_W = SEC_W + SEC_SHIFT;

  logic [SEC_W-1:0] sec_q;
  logic [CNT_W-1:0] rem_q, cons_q, step;
  logic [LIN_W-1:0] lin;
  logic             data_rd;

  assign two_left_o = rem_q >= CNT_W'(2);
  assign data_rd    = rd_en_i && (acc_i == ACC_WORD || acc_i == ACC_BYTE) && (rem_q != '0);
  assign step       = (acc_i == ACC_WORD && two_left_o) ? CNT_W'(2) : CNT_W'(1);
  assign lin        = {sec_q, {SEC_SHIFT{1'b0}}} + LIN_W'(cons_q);
  assign mem_addr_o = lin[MEM_AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q  <= '0;
      rem_q  <= '0;
      cons_q <= '0;
    end else begin
      if (wr_en_i) begin
        case (acc_i)
          ACC_A0:    sec_q <= sec_q | SEC_W'(wdata_i);
          ACC_A1:    sec_q <= sec_q | (SEC_W'(wdata_i) << 8);
          ACC_A2:    sec_q <= sec_q | (SEC_W'(wdata_i) << 16);
          ACC_A3:    sec_q <= sec_q | (SEC_W'(wdata_i[4:0]) << 24);
          ACC_COUNT: begin
            rem_q  <= {wdata_i, {SEC_SHIFT{1'b0}}};
            cons_q <= '0;
          end
          default: ;
        endcase
      end
      if (data_rd) begin
        if (rem_q == step) begin
          rem_q  <= '0;
          cons_q <= '0;
          sec_q  <= '0;
        end else begin
          rem_q  <= rem_q - step;
          cons_q <= cons_q + step;
        end
      end
    end
  end

  assign sector_o    = sec_q;
  assign remaining_o = rem_q;
endmodule

// File: rtl/ata_pio_mem.sv
module ata_pio_mem #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rd_lo_o,
  output logic [7:0]    rd_hi_o
);
  logic [7:0] mem_q [DEPTH];
  logic [AW-1:0] raddr_nx;

  assign raddr_nx = raddr_i + AW'(1);  // wraps at the top of memory

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rd_lo_o = mem_q[raddr_i];
  assign rd_hi_o = mem_q[raddr_nx];
endmodule

// File: rtl/ata_pio_target.sv
module ata_pio_target
  import ata_pio_pkg::*;
#(
  parameter int MEM_SECTORS = 4,
  parameter int MEM_BYTES   = MEM_SECTORS << SEC_SHIFT,
  parameter int MEM_AW      = $clog2(MEM_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [5:0]        addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [7:0]        wdata_i,
  output logic [15:0]       rdata_o,
  input  logic              bd_we_i,
  input  logic [MEM_AW-1:0] bd_addr_i,
  input  logic [7:0]        bd_data_i
);
  acc_e              acc;
  logic [SEC_W-1:0]  sector_q;
  logic [CNT_W-1:0]  remaining_q;
  logic [MEM_AW-1:0] mem_addr;
  logic              two_left;
  logic [7:0]        rd_lo, rd_hi, err_q;
  logic [15:0]       rdata_d, rdata_q;

  ata_pio_regdec u_dec (
    .addr_i (addr_i),
    .acc_o  (acc)
  );

  ata_pio_xfer #(.MEM_AW(MEM_AW)) u_xfer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .rd_en_i     (rd_en_i),
    .acc_i       (acc),
    .wdata_i     (wdata_i),
    .sector_o    (sector_q),
    .remaining_o (remaining_q),
    .mem_addr_o  (mem_addr),
    .two_left_o  (two_left)
  );

  ata_pio_mem #(.DEPTH(MEM_BYTES), .AW(MEM_AW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (bd_we_i),
    .waddr_i (bd_addr_i),
    .wdata_i (bd_data_i),
    .raddr_i (mem_addr),
    .rd_lo_o (rd_lo),
    .rd_hi_o (rd_hi)
  );

  always_comb begin
    rdata_d = '0;
    case (acc)
      ACC_WORD: if (remaining_q != '0) rdata_d = {two_left ? rd_hi : 8'h00, rd_lo};
      ACC_BYTE: if (remaining_q != '0) rdata_d = {8'h00, rd_lo};
      ACC_ERR:  rdata_d = {8'h00, err_q};
      ACC_CMD:  rdata_d = {8'h00, ST_READY};
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= '0;
    end else begin
      if (rd_en_i) rdata_q <= rdata_d;
      if (wr_en_i && acc == ACC_CMD) begin
        case (wdata_i)
          CMD_RD, CMD_WR, CMD_ID, CMD_FEAT: err_q <= '0;
          default:                          err_q <= ERR_ABORT;
        endcase
      end
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/ata_pio_target_chk.sv
module ata_pio_target_chk
  import ata_pio_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [5:0]       addr_i,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic [7:0]       wdata_i,
  input logic [15:0]      rdata_o,
  input logic [SEC_W-1:0] sector_i,
  input logic [CNT_W-1:0] remaining_i
);
  logic data_port, rd_mapped;
  assign data_port = (addr_i == OFF_WORD) || (addr_i == OFF_BYTE);
  assign rd_mapped = data_port || (addr_i == OFF_ERR) || (addr_i == OFF_CMD);

  p_status_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == OFF_CMD) |=> (rdata_o == 16'h0008));

  p_unmapped_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rd_mapped) |=> (rdata_o == 16'h0000));

  p_empty_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && data_port && remaining_i == '0)
    |=> (rdata_o == 16'h0000 && remaining_i == '0));

  p_byte_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && addr_i == OFF_BYTE && remaining_i != '0)
    |=> (remaining_i == $past(remaining_i) - CNT_W'(1)));

  p_word_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && addr_i == OFF_WORD && remaining_i >= CNT_W'(2))
    |=> (remaining_i == $past(remaining_i) - CNT_W'(2)));

  p_done_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && data_port && remaining_i != '0)
    |=> (remaining_i != '0 || sector_i == '0));

  p_count_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !rd_en_i && addr_i == OFF_COUNT)
    |=> (remaining_i == {$past(wdata_i), {SEC_SHIFT{1'b0}}}));

  p_top_bits_or_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !rd_en_i && addr_i == OFF_A3)
    |=> (sector_i[28:24] == ($past(sector_i[28:24]) | $past(wdata_i[4:0]))));
endmodule

bind ata_pio_target ata_pio_target_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .wr_en_i     (wr_en_i),
  .rd_en_i     (rd_en_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .sector_i    (sector_q),
  .remaining_i (remaining_q)
);

// File: tb/ata_pio_target_bench.sv
module ata_pio_target_bench;
  localparam int NSEC = 4;
  localparam int MEMB = NSEC * 512;
  localparam int AW   = $clog2(MEMB);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [5:0]    addr_i = '0;
  logic          wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [7:0]    wdata_i = '0;
  logic [15:0]   rdata_o;
  logic          bd_we_i = 1'b0;
  logic [AW-1:0] bd_addr_i = '0;
  logic [7:0]    bd_data_i = '0;

  int checks = 0, fails = 0;
  logic [7:0] mem_m [MEMB];
  int sec_m = 0, rem_m = 0, cons_m = 0;

  always #5 clk_i = ~clk_i;

  ata_pio_target #(.MEM_SECTORS(NSEC)) u_ata_pio_target (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .rd_en_i, .wdata_i, .rdata_o,
    .bd_we_i, .bd_addr_i, .bd_data_i
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + (i >> 7)) ^ 8'h5A);
  endfunction

  function automatic int cur_idx();
    return ((sec_m % NSEC) * 512 + cons_m) % MEMB;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i); wr_en_i = 1'b0;
    case (a)
      6'h27: sec_m = sec_m | int'(d);
      6'h29: sec_m = sec_m | (int'(d) << 8);
      6'h2B: sec_m = sec_m | (int'(d) << 16);
      6'h2D: sec_m = sec_m | (int'(d[4:0]) << 24);
      6'h25: begin rem_m = int'(d) * 512; cons_m = 0; end
      default: ;
    endcase
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk_i); addr_i = a; rd_en_i = 1'b1;
    @(negedge clk_i); rd_en_i = 1'b0; d = rdata_o;
  endtask

  task automatic advance(input int n);
    if (rem_m == n) begin rem_m = 0; cons_m = 0; sec_m = 0; end
    else begin rem_m -= n; cons_m += n; end
  endtask

  task automatic rd_data_chk(input bit word, input string req);
    logic [15:0] got, exp;
    int idx, n;
    idx = cur_idx();
    if (rem_m == 0) begin exp = '0; n = 0; end
    else if (word && rem_m >= 2) begin exp = {mem_m[(idx + 1) % MEMB], mem_m[idx]}; n = 2; end
    else begin exp = {8'h00, mem_m[idx]}; n = 1; end
    rd(word ? 6'h20 : 6'h21, got);
    chk(req, got, exp);
    if (n != 0) advance(n);
  endtask

  // byte read with a backdoor write in the same cycle
  task automatic rd_byte_bd(input int tgt, input logic [7:0] nv, input string req);
    logic [15:0] exp;
    exp = {8'h00, mem_m[cur_idx()]};
    @(negedge clk_i); addr_i = 6'h21; rd_en_i = 1'b1;
    bd_we_i = 1'b1; bd_addr_i = AW'(tgt); bd_data_i = nv;
    @(negedge clk_i); rd_en_i = 1'b0; bd_we_i = 1'b0;
    chk(req, rdata_o, exp);
    mem_m[tgt] = nv;
    advance(1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R12, R7, R8, R9: reset state
    rd(6'h21, d); chk("R12 byte read after reset", d, 16'h0000);
    rd(6'h20, d); chk("R12 word read after reset", d, 16'h0000);
    rd(6'h2F, d); chk("R8 status after reset", d, 16'h0008);
    rd(6'h23, d); chk("R9 error after reset", d, 16'h0000);

    // preload through the backdoor (R11)
    for (int i = 0; i < MEMB; i++) begin
      @(negedge clk_i); bd_we_i = 1'b1; bd_addr_i = AW'(i); bd_data_i = pat(i);
      mem_m[i] = pat(i);
    end
    @(negedge clk_i); bd_we_i = 1'b0;

    // R4, R6: full byte sweep of sector 1
    wr(6'h27, 8'h01); wr(6'h25, 8'h01);
    for (int i = 0; i < 512; i++) rd_data_chk(1'b0, "R4 byte sweep");
    rd(6'h21, d); chk("R7 read after drain", d, 16'h0000);
    // R6: address cleared, count 1 reads sector 0
    wr(6'h25, 8'h01);
    rd_data_chk(1'b0, "R6 address cleared");
    for (int i = 1; i < 512; i++) rd_data_chk(1'b1, "R5 word drain");

    // R5: word sweep of sector 2
    wr(6'h27, 8'h02); wr(6'h25, 8'h01);
    for (int i = 0; i < 256; i++) rd_data_chk(1'b1, "R5 word sweep");

    // R3, R5, R6: two sectors from sector 3, odd start, wraps into sector 0
    wr(6'h27, 8'h03); wr(6'h25, 8'h02);
    rd_data_chk(1'b0, "R3 two-sector first byte");
    for (int i = 0; i < 512; i++) rd_data_chk(1'b1, "R5 odd-aligned words");
    rd(6'h25, d); chk("R10 count offset reads zero", d, 16'h0000);
    rd(6'h20, d); chk("R7 word read at zero count", d, 16'h0000);

    // R2: OR accumulation, high bits do not reach the memory window
    wr(6'h27, 8'h01); wr(6'h27, 8'h02);
    wr(6'h29, 8'h54); wr(6'h2B, 8'hA8); wr(6'h2D, 8'hFC);
    wr(6'h25, 8'h01);
    for (int i = 0; i < 8; i++) rd_data_chk(1'b1, "R2 OR of address bytes");
    for (int i = 8; i < 256; i++) rd_data_chk(1'b1, "R2 drain");

    // R9: command decode into the error register
    wr(6'h2F, 8'h55); rd(6'h23, d); chk("R9 unknown sets error", d, 16'h0004);
    rd(6'h2F, d); chk("R8 status unchanged by error", d, 16'h0008);
    wr(6'h2F, 8'hEC); rd(6'h23, d); chk("R9 identify clears", d, 16'h0000);
    wr(6'h2F, 8'h00); rd(6'h23, d); chk("R9 zero code sets", d, 16'h0004);
    wr(6'h2F, 8'h20); rd(6'h23, d); chk("R9 read code clears", d, 16'h0000);
    wr(6'h2F, 8'hFF); wr(6'h2F, 8'h30); rd(6'h23, d); chk("R9 write code clears", d, 16'h0000);
    wr(6'h2F, 8'h21); wr(6'h2F, 8'hEF); rd(6'h23, d); chk("R9 feature code clears", d, 16'h0000);

    // R10: unmapped reads
    rd(6'h00, d); chk("R10 offset 00", d, 16'h0000);
    rd(6'h22, d); chk("R10 offset 22", d, 16'h0000);
    rd(6'h27, d); chk("R10 offset 27", d, 16'h0000);
    rd(6'h2D, d); chk("R10 offset 2D", d, 16'h0000);
    rd(6'h30, d); chk("R10 offset 30", d, 16'h0000);
    rd(6'h3F, d); chk("R10 offset 3F", d, 16'h0000);

    // R10, R11: ignored writes and backdoor collisions mid-transfer
    wr(6'h27, 8'h01); wr(6'h25, 8'h01);
    for (int i = 0; i < 5; i++) rd_data_chk(1'b0, "R10 pre-write bytes");
    wr(6'h21, 8'hFF); wr(6'h23, 8'hFF); wr(6'h00, 8'hFF); wr(6'h3F, 8'hFF);
    rd_data_chk(1'b0, "R10 transfer unaffected by ignored writes");
    rd(6'h23, d); chk("R10 error unaffected", d, 16'h0000);
    rd_byte_bd(cur_idx(), 8'hC3, "R11 same-byte read returns old");
    rd_byte_bd(cur_idx() + 1, 8'h3C, "R11 read beside next-byte write");
    rd_data_chk(1'b0, "R11 next byte shows new content");
    for (int i = 9; i < 512; i++) rd_data_chk(1'b0, "R4 drain");

    // R3, R7: zero count
    wr(6'h25, 8'h00);
    rd(6'h21, d); chk("R7 byte read with count zero", d, 16'h0000);
    rd(6'h20, d); chk("R7 word read with count zero", d, 16'h0000);
    rd(6'h2F, d); chk("R1 status offset still decodes", d, 16'h0008);

    summary();
    $finish;
  end
endmodule